// File: doc/BRIEF.md
# Extended Mantissa Add/Subtract with Carry Renormalization

This block adds or subtracts two extended mantissas. Each operand is a 64-bit mantissa with an 8-bit guard byte below it, 72 bits in all. The block runs one chained operation across the whole 72 bits, starting at the guard byte. In add mode a carry out of the top mantissa bit is folded back into the result. The mantissa moves right by one place with its top bit set, the low bits end up in a sticky guard byte, and the destination exponent goes up by one. If that increment reaches the all-ones exponent, the result saturates instead: the mantissa is cleared and sticky overflow and inexact flags are raised. Operands are expected to be aligned already, and rounding happens downstream.

Operands enter on a valid/ready stream and results leave on a valid/ready stream, with one result register between them. A transfer happens on a rising clock edge where valid and ready are both high. The input side is ready whenever the result register is empty or its content is being taken in the same cycle. While the output is valid and not ready, the result holds still and no new operand is accepted. The flag outputs and the flag clear input are plain level signals.

Top module: `xmant_addnorm`

## Requirements
- R1: After reset, out_valid is 0 and both flags are 0.
- R2: With op_sub=0 and no carry out of bit 71 of {mant,guard}, the result is the 72-bit sum. res_exp equals exp_in, res_renorm is 0 and the flags do not change.
- R3: With op_sub=1 the result is {a_mant,a_guard} minus {b_mant,b_guard} modulo 2^72. res_exp equals exp_in, res_renorm is 0 and the flags do not change, even when a is smaller than b.
- R4: On an add carry where exp_in+1 (modulo 2^15) is not 0x7FFF, res_exp is exp_in+1 and res_mant is the summed mantissa shifted right by one with bit 63 set to 1. res_renorm is 1.
- R5: In the R4 case res_guard bit 7 holds bit 0 of the summed mantissa, bits 6 to 1 are 0, and bit 0 is 1 exactly when the summed guard byte is nonzero.
- R6: On an add carry where exp_in+1 equals 0x7FFF, res_mant is 0, res_exp is 0x7FFF, res_guard is the summed guard byte, res_renorm is 0 and flag_ovf becomes 1.
- R7: In the R6 case flag_inx becomes 1 only if the summed 64-bit mantissa was nonzero before clearing.
- R8: The flags stay set until flag_clr is high at a clock edge. If clr and a new set arrive at the same edge, the set wins.
- R9: in_ready is high when out_valid is 0 or out_ready is 1. A result appears on the edge that accepts its operands. While out_valid is 1 and out_ready is 0, all result outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set is offered |
| in_ready | output | 1 | Block can accept an operand set |
| a_mant | input | 64 | First operand mantissa |
| a_guard | input | 8 | First operand guard byte |
| b_mant | input | 64 | Second operand mantissa |
| b_guard | input | 8 | Second operand guard byte |
| exp_in | input | 15 | Destination exponent |
| op_sub | input | 1 | 0 = add, 1 = first minus second |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| res_mant | output | 64 | Result mantissa |
| res_guard | output | 8 | Result guard byte |
| res_exp | output | 15 | Result exponent |
| res_renorm | output | 1 | 1 when a carry shift was applied |
| flag_clr | input | 1 | Clears both sticky flags |
| flag_ovf | output | 1 | Sticky exponent overflow flag |
| flag_inx | output | 1 | Sticky inexact flag |

## Verification
A broken carry link between guard byte and mantissa, or between the two mantissa halves, shows up on the next result as a wrong low mantissa word or a missed renormalization. The directed cases are chosen so that carries run across every chunk boundary. A wrong saturation decision shows up in the same cycle as the result, through res_exp, res_renorm and flag_ovf. A flag register that fails to hold or to clear shows up one cycle after the operation or clear that should have changed it, so the flags are read after every step. A faulty hold under back-pressure shows up as result outputs that change while out_ready is low.

// File: rtl/xmant_pkg.sv
package xmant_pkg;
  localparam int DEF_MANT_W  = 64;
  localparam int DEF_GUARD_W = 8;
  localparam int DEF_EXP_W   = 15;
  localparam int DEF_CHUNK_W = 8;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } xop_e;
endpackage

// File: rtl/xmant_chunk_adder.sv
// Chained adder over the extended mantissa, split into equal chunks.
module xmant_chunk_adder #(
  parameter int EXT_W   = 72,
  parameter int CHUNK_W = 8
) (
  input  logic [EXT_W-1:0] a,
  input  logic [EXT_W-1:0] b,
  input  logic             sub,
  output logic [EXT_W-1:0] sum,
  output logic             carry_out
);
  localparam int NCH = EXT_W / CHUNK_W;

  logic [EXT_W-1:0] b_eff;
  logic [NCH:0]     link;

  assign b_eff   = sub ? ~b : b;
  assign link[0] = sub;

  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    logic [CHUNK_W:0] part;
    assign part = {1'b0, a[g*CHUNK_W +: CHUNK_W]}
                + {1'b0, b_eff[g*CHUNK_W +: CHUNK_W]}
                + {{CHUNK_W{1'b0}}, link[g]};
    assign sum[g*CHUNK_W +: CHUNK_W] = part[CHUNK_W-1:0];
    assign link[g+1] = part[CHUNK_W];
  end

  // a borrow in subtract mode is not reported
  assign carry_out = link[NCH] & ~sub;
endmodule

// File: rtl/xmant_renorm.sv
// Folds an add carry back into the mantissa, or saturates the exponent.
module xmant_renorm #(
  parameter int MANT_W  = 64,
  parameter int GUARD_W = 8,
  parameter int EXP_W   = 15
) (
  input  logic [MANT_W-1:0]  sum_mant,
  input  logic [GUARD_W-1:0] sum_guard,
  input  logic               carry,
  input  logic [EXP_W-1:0]   exp_in,
  output logic [MANT_W-1:0]  mant_o,
  output logic [GUARD_W-1:0] guard_o,
  output logic [EXP_W-1:0]   exp_o,
  output logic               renorm_o,
  output logic               ovf_o,
  output logic               inx_o
);
  logic [EXP_W-1:0]   exp_inc;
  logic               sat;
  logic [GUARD_W-1:0] shifted_guard;

  assign exp_inc = exp_in + 1'b1;
  assign sat     = &exp_inc;
  assign shifted_guard = {sum_mant[0], {(GUARD_W-2){1'b0}}, |sum_guard};

  always_comb begin
    mant_o   = sum_mant;
    guard_o  = sum_guard;
    exp_o    = exp_in;
    renorm_o = 1'b0;
    ovf_o    = 1'b0;
    inx_o    = 1'b0;
    if (carry) begin
      exp_o = exp_inc;
      if (sat) begin
        mant_o = '0;
        ovf_o  = 1'b1;
        inx_o  = |sum_mant;
      end else begin
        mant_o   = {1'b1, sum_mant[MANT_W-1:1]};
        guard_o  = shifted_guard;
        renorm_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xmant_flag_hold.sv
// Sticky status bits; a set at the same edge as a clear survives.
module xmant_flag_hold #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [NFLAG-1:0] set,
  output logic [NFLAG-1:0] q
);
  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q[f] <= 1'b0;
      else if (clr) q[f] <= set[f];
      else          q[f] <= q[f] | set[f];
    end
  end
endmodule

// File: rtl/xmant_addnorm.sv
module xmant_addnorm
  import xmant_pkg::*;
#(
  parameter int MANT_W  = DEF_MANT_W,
  parameter int GUARD_W = DEF_GUARD_W,
  parameter int EXP_W   = DEF_EXP_W,
  parameter int CHUNK_W = DEF_CHUNK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [MANT_W-1:0]  a_mant,
  input  logic [GUARD_W-1:0] a_guard,
  input  logic [MANT_W-1:0]  b_mant,
  input  logic [GUARD_W-1:0] b_guard,
  input  logic [EXP_W-1:0]   exp_in,
  input  logic               op_sub,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [MANT_W-1:0]  res_mant,
  output logic [GUARD_W-1:0] res_guard,
  output logic [EXP_W-1:0]   res_exp,
  output logic               res_renorm,
  input  logic               flag_clr,
  output logic               flag_ovf,
  output logic               flag_inx
);
  localparam int EXT_W = MANT_W + GUARD_W;

  xop_e               op;
  logic               accept;
  logic [EXT_W-1:0]   sum;
  logic               carry;
  logic [MANT_W-1:0]  n_mant;
  logic [GUARD_W-1:0] n_guard;
  logic [EXP_W-1:0]   n_exp;
  logic               n_renorm;
  logic               n_ovf;
  logic               n_inx;
  logic [1:0]         flag_q;

  assign op       = xop_e'(op_sub);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  xmant_chunk_adder #(.EXT_W(EXT_W), .CHUNK_W(CHUNK_W)) u_add (
    .a         ({a_mant, a_guard}),
    .b         ({b_mant, b_guard}),
    .sub       (op == OP_SUB),
    .sum       (sum),
    .carry_out (carry)
  );

  xmant_renorm #(.MANT_W(MANT_W), .GUARD_W(GUARD_W), .EXP_W(EXP_W)) u_norm (
    .sum_mant  (sum[EXT_W-1:GUARD_W]),
    .sum_guard (sum[GUARD_W-1:0]),
    .carry     (carry),
    .exp_in    (exp_in),
    .mant_o    (n_mant),
    .guard_o   (n_guard),
    .exp_o     (n_exp),
    .renorm_o  (n_renorm),
    .ovf_o     (n_ovf),
    .inx_o     (n_inx)
  );

  xmant_flag_hold #(.NFLAG(2)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (flag_clr),
    .set   ({n_inx & accept, n_ovf & accept}),
    .q     (flag_q)
  );

  assign flag_ovf = flag_q[0];
  assign flag_inx = flag_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      res_mant   <= '0;
      res_guard  <= '0;
      res_exp    <= '0;
      res_renorm <= 1'b0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        res_mant   <= n_mant;
        res_guard  <= n_guard;
        res_exp    <= n_exp;
        res_renorm <= n_renorm;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xmant_addnorm_chk.sv
module xmant_addnorm_chk #(
  parameter int MANT_W  = 64,
  parameter int GUARD_W = 8,
  parameter int EXP_W   = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [MANT_W-1:0]  res_mant,
  input logic [GUARD_W-1:0] res_guard,
  input logic [EXP_W-1:0]   res_exp,
  input logic               res_renorm,
  input logic               flag_clr,
  input logic               flag_ovf,
  input logic               flag_inx
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_mant)
      && $stable(res_guard) && $stable(res_exp) && $stable(res_renorm));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_shift_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && res_renorm |-> res_mant[MANT_W-1]);

  assert_guard_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && res_renorm |-> res_guard[GUARD_W-2:1] == '0);

  assert_sticky_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovf && !flag_clr |=> flag_ovf);

  assert_sticky_inx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inx && !flag_clr |=> flag_inx);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !in_valid |=> !flag_ovf && !flag_inx);

  assert_inx_needs_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inx |-> flag_ovf);
endmodule

bind xmant_addnorm xmant_addnorm_chk #(
  .MANT_W(MANT_W), .GUARD_W(GUARD_W), .EXP_W(EXP_W)
) u_chk (.*);

// File: tb/test_xmant_addnorm.sv
module test_xmant_addnorm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] a_mant = '0;
  logic [7:0]  a_guard = '0;
  logic [63:0] b_mant = '0;
  logic [7:0]  b_guard = '0;
  logic [14:0] exp_in = '0;
  logic        op_sub = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] res_mant;
  logic [7:0]  res_guard;
  logic [14:0] res_exp;
  logic        res_renorm;
  logic        flag_clr = 1'b0;
  logic        flag_ovf;
  logic        flag_inx;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit m_ovf = 1'b0;
  bit m_inx = 1'b0;

  always #5 clk = ~clk;

  xmant_addnorm i_xmant_addnorm (.*);

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one operation, let it be accepted, and check it against a model
  // built from the requirements.
  task automatic run_op(input string req, input logic [63:0] am, input logic [7:0] ag,
                        input logic [63:0] bm, input logic [7:0] bg,
                        input logic [14:0] ex, input logic sub, input logic clr);
    logic [72:0] full;
    logic [63:0] em;
    logic [7:0]  eg;
    logic [14:0] ee;
    logic [14:0] inc;
    logic        er;
    if (sub) full = {1'b0, am, ag} - {1'b0, bm, bg};
    else     full = {1'b0, am, ag} + {1'b0, bm, bg};
    em = full[71:8]; eg = full[7:0]; ee = ex; er = 1'b0;
    if (clr) begin m_ovf = 1'b0; m_inx = 1'b0; end
    if (!sub && full[72]) begin
      inc = ex + 15'd1;
      ee = inc;
      if (inc == 15'h7FFF) begin
        m_ovf = 1'b1;
        if (em != 64'd0) m_inx = 1'b1;
        em = '0;
      end else begin
        eg = {em[0], 6'd0, (full[7:0] != 8'd0)};
        em = {1'b1, em[63:1]};
        er = 1'b1;
      end
    end
    @(negedge clk);
    a_mant = am; a_guard = ag; b_mant = bm; b_guard = bg;
    exp_in = ex; op_sub = sub; in_valid = 1'b1; flag_clr = clr;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
    chk({req, " valid"}, {79'd0, out_valid}, 80'd1);
    chk({req, " mant"}, {16'd0, res_mant}, {16'd0, em});
    chk({req, " guard"}, {72'd0, res_guard}, {72'd0, eg});
    chk({req, " exp"}, {65'd0, res_exp}, {65'd0, ee});
    chk({req, " renorm"}, {79'd0, res_renorm}, {79'd0, er});
    chk({req, " ovf flag"}, {79'd0, flag_ovf}, {79'd0, m_ovf});
    chk({req, " inx flag"}, {79'd0, flag_inx}, {79'd0, m_inx});
  endtask

  task automatic clear_flags();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    m_ovf = 1'b0; m_inx = 1'b0;
    chk("R8 clear ovf", {79'd0, flag_ovf}, 80'd0);
    chk("R8 clear inx", {79'd0, flag_inx}, 80'd0);
  endtask

  task automatic test_reset();
    chk("R1 out_valid", {79'd0, out_valid}, 80'd0);
    chk("R1 ovf", {79'd0, flag_ovf}, 80'd0);
    chk("R1 inx", {79'd0, flag_inx}, 80'd0);
  endtask

  task automatic test_plain_add();
    run_op("R2 add guard carry", 64'h4000_0000_0000_0001, 8'h10,
           64'h1000_0000_0000_0002, 8'hF8, 15'h1234, 1'b0, 1'b0);
    run_op("R2 add word carry", 64'h0000_0000_FFFF_FFFF, 8'hFF,
           64'h0000_0000_0000_0000, 8'h01, 15'h0001, 1'b0, 1'b0);
  endtask

  task automatic test_sub();
    run_op("R3 sub borrow chain", 64'h8000_0000_0000_0000, 8'h00,
           64'h0000_0000_0000_0001, 8'h01, 15'h2000, 1'b1, 1'b0);
    run_op("R3 sub negative", 64'h0000_0000_0000_0001, 8'h00,
           64'h0000_0000_0000_0002, 8'h00, 15'h7FFE, 1'b1, 1'b0);
  endtask

  task automatic test_carry_shift();
    run_op("R4 R5 carry sticky guard", 64'hFFFF_FFFF_FFFF_FFFF, 8'h01,
           64'h0000_0000_0000_0000, 8'hFF, 15'h3FFF, 1'b0, 1'b0);
    run_op("R4 R5 carry odd bit", 64'h8000_0000_0000_0001, 8'h00,
           64'h8000_0000_0000_0002, 8'h00, 15'h0010, 1'b0, 1'b0);
    run_op("R4 exponent wrap", 64'hC000_0000_0000_0000, 8'h00,
           64'hC000_0000_0000_0000, 8'h00, 15'h7FFF, 1'b0, 1'b0);
  endtask

  task automatic test_overflow();
    run_op("R6 R7 overflow inexact", 64'hC000_0000_0000_0000, 8'h22,
           64'hC000_0000_0000_0000, 8'h11, 15'h7FFE, 1'b0, 1'b0);
    run_op("R8 flags hold", 64'h0000_0000_0000_0001, 8'h00,
           64'h0000_0000_0000_0001, 8'h00, 15'h0005, 1'b0, 1'b0);
    clear_flags();
    run_op("R6 R7 overflow exact", 64'h8000_0000_0000_0000, 8'h00,
           64'h8000_0000_0000_0000, 8'h00, 15'h7FFE, 1'b0, 1'b0);
    run_op("R8 set beats clear", 64'hF000_0000_0000_0000, 8'h00,
           64'hF000_0000_0000_0000, 8'h00, 15'h7FFE, 1'b0, 1'b1);
    clear_flags();
  endtask

  task automatic test_backpressure();
    logic [63:0] held;
    @(negedge clk);
    out_ready = 1'b0;
    a_mant = 64'h0000_0000_0000_0100; a_guard = 8'h00;
    b_mant = 64'h0000_0000_0000_0023; b_guard = 8'h00;
    exp_in = 15'h0042; op_sub = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk("R9 accepted", {79'd0, out_valid}, 80'd1);
    held = res_mant;
    chk("R9 first result", {16'd0, held}, 80'h0000_0000_0000_0000_0123);
    a_mant = 64'h0000_0000_0000_0999;
    repeat (3) @(negedge clk);
    chk("R9 stall ready", {79'd0, in_ready}, 80'd0);
    chk("R9 hold mant", {16'd0, res_mant}, {16'd0, held});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next result", {16'd0, res_mant}, 80'h0000_0000_0000_0000_09BC);
    @(negedge clk);
    chk("R9 drained", {79'd0, out_valid}, 80'd0);
    chk("R9 ready idle", {79'd0, in_ready}, 80'd1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_plain_add();
    test_sub();
    test_carry_shift();
    test_overflow();
    test_backpressure();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule